// File: doc/BRIEF.md
# Chip-Enable Framed 4096 x 1 Bit Memory

This block is a cycle-based model of a 4096-entry, one-bit-wide static memory. Its operations are framed by an active-low chip-enable strobe. A fast system clock samples every input (chip enable, write enable, a 12-bit address and a data bit), and the block finds strobe edges internally. The address is latched when chip enable falls. After that edge the level of write enable selects one of three kinds of cycle: a read, an early write, or a read-modify-write. A data output is paired with an output-valid flag, which stands in for a tristate pin. A second flag marks the case in which the output would otherwise be undefined.

The access time and the minimum lead of write enable over the rising chip-enable edge are parameters counted in system clocks. Storage is committed when chip enable rises. The cells have no reset. A reset of the block clears only the cycle control state, so the contents survive it. While chip enable stays high the block is in standby, and no input has any effect.

Top module: `sram4k_ce_model`

## Requirements
- R1: While reset is held and after it is released, `dout_en` and `dout_undef` are 0 until a cycle starts.
- R2: In a read cycle (write enable high at the chip-enable falling edge), `dout_en` is 0 during the access window. It goes to 1 exactly ACC_CLKS+2 clocks after chip enable is driven low, with `dout` equal to the cell at the latched address.
- R3: The address is latched at the chip-enable falling edge. Address changes later in the same cycle do not change which cell is read or written.
- R4: `dout_en` returns to 0 within two clocks of chip enable being driven high.
- R5: In an early write (write enable already low at the chip-enable falling edge), the data bit is taken at that edge. Later changes of `din` are ignored, and `dout_en` stays 0 for the whole cycle.
- R6: In a read-modify-write cycle (write enable falls while chip enable is low), `din` is taken at the write-enable falling edge. `dout` keeps showing the old cell value until chip enable rises.
- R7: A read-modify-write is committed only if chip enable is driven high at least LEAD_CLKS clocks after write enable is driven low. With a shorter lead the cell keeps its old value.
- R8: If write enable falls before the access time has elapsed, `dout_en`=1, `dout`=0 and `dout_undef`=1 until chip enable rises. The write still follows R7.
- R9: Reset does not change stored data.
- R10: While chip enable is high, activity on write enable, address and data changes neither the outputs (`dout_en`=0) nor the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Active-low chip enable that frames a cycle |
| we_n | input | 1 | Active-low write enable |
| addr | input | 12 | Cell address, latched when ce_n falls |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, meaningful when dout_en is 1 |
| dout_en | output | 1 | Output-driven flag; 0 stands for high impedance |
| dout_undef | output | 1 | Flags an output made undefined by an early write-enable fall |

## Verification
The checker watches control state on every cycle. In idle and early-write states the output must stay disabled, and it must stay disabled during an unfinished read access window. It must drop once chip enable rises. The undefined-output flag must come with a driven zero, and a storage write may happen only at a rising chip-enable edge. Only the bench scenarios can show whether the right data lands in the right cell. The same holds for the exact clock on which read data appears, for address and data changes being ignored after latching, for the lead-time rule, and for contents surviving reset.

// File: rtl/sram4k_pkg.sv
package sram4k_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_READ   = 2'd1,
    CYC_EWRITE = 2'd2,
    CYC_RMW    = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          we_s,
  output logic [AW-1:0] addr_s,
  output logic          din_s,
  output logic          ce_fall,
  output logic          ce_rise,
  output logic          we_fall
);
  logic ce_s, ce_p, we_p;

  // Sample stage and previous-sample stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_s   <= 1'b1;
      we_s   <= 1'b1;
      ce_p   <= 1'b1;
      we_p   <= 1'b1;
      addr_s <= '0;
      din_s  <= 1'b0;
    end else begin
      ce_s   <= ce_n;
      we_s   <= we_n;
      ce_p   <= ce_s;
      we_p   <= we_s;
      addr_s <= addr;
      din_s  <= din;
    end
  end

  assign ce_fall = ce_p & ~ce_s;
  assign ce_rise = ~ce_p & ce_s;
  assign we_fall = we_p & ~we_s;
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram4k_pkg::*;
#(
  parameter int AW        = 12,
  parameter int ACC_CLKS  = 20,
  parameter int LEAD_CLKS = 4,
  localparam int TW = $clog2(ACC_CLKS + 1),
  localparam int LW = $clog2(LEAD_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_fall,
  input  logic          ce_rise,
  input  logic          we_fall,
  input  logic          we_s,
  input  logic [AW-1:0] addr_s,
  input  logic          din_s,
  input  logic          rd_bit,
  output cyc_kind_e     mode,
  output logic [TW-1:0] acc_cnt,
  output logic [AW-1:0] addr_l,
  output logic          wr_en,
  output logic          wr_bit,
  output logic          dout,
  output logic          dout_en,
  output logic          dout_undef
);
  cyc_kind_e     mode_n;
  logic [AW-1:0] addr_n;
  logic          data_q, data_n;
  logic [TW-1:0] acc_n;
  logic [LW-1:0] lead_q, lead_n;
  logic          undef_q, undef_n;
  logic          acc_open;

  assign acc_open = (acc_cnt < TW'(ACC_CLKS));

  always_comb begin
    mode_n  = mode;
    addr_n  = addr_l;
    data_n  = data_q;
    acc_n   = acc_cnt;
    lead_n  = lead_q;
    undef_n = undef_q;
    wr_en   = 1'b0;
    unique case (mode)
      CYC_IDLE: begin
        if (ce_fall) begin
          addr_n  = addr_s;
          acc_n   = '0;
          lead_n  = '0;
          undef_n = 1'b0;
          if (!we_s) begin
            mode_n = CYC_EWRITE;
            data_n = din_s;
          end else begin
            mode_n = CYC_READ;
          end
        end
      end
      CYC_READ: begin
        if (acc_open) acc_n = acc_cnt + TW'(1);
        if (ce_rise) begin
          mode_n  = CYC_IDLE;
          undef_n = 1'b0;
        end else if (we_fall) begin
          mode_n  = CYC_RMW;
          data_n  = din_s;
          lead_n  = LW'(1);
          undef_n = acc_open;
        end
      end
      CYC_EWRITE: begin
        if (ce_rise) begin
          wr_en  = 1'b1;
          mode_n = CYC_IDLE;
        end
      end
      CYC_RMW: begin
        if (acc_open) acc_n = acc_cnt + TW'(1);
        if (lead_q < LW'(LEAD_CLKS)) lead_n = lead_q + LW'(1);
        if (ce_rise) begin
          wr_en   = (lead_q >= LW'(LEAD_CLKS));
          mode_n  = CYC_IDLE;
          undef_n = 1'b0;
        end
      end
      default: mode_n = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= CYC_IDLE;
      addr_l  <= '0;
      data_q  <= 1'b0;
      acc_cnt <= '0;
      lead_q  <= '0;
      undef_q <= 1'b0;
    end else begin
      mode    <= mode_n;
      addr_l  <= addr_n;
      data_q  <= data_n;
      acc_cnt <= acc_n;
      lead_q  <= lead_n;
      undef_q <= undef_n;
    end
  end

  assign wr_bit     = data_q;
  assign dout_en    = ((mode == CYC_READ) || (mode == CYC_RMW)) && (!acc_open || undef_q);
  assign dout       = undef_q ? 1'b0 : rd_bit;
  assign dout_undef = undef_q;
endmodule

// File: rtl/sram_bit_array.sv
module sram_bit_array #(
  parameter int AW = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_bit;
  end

  assign rd_bit = cells[rd_addr];
endmodule

// File: rtl/sram4k_ce_model.sv
module sram4k_ce_model
  import sram4k_pkg::*;
#(
  parameter int AW        = 12,
  parameter int ACC_CLKS  = 20,
  parameter int LEAD_CLKS = 4,
  localparam int TW = $clog2(ACC_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          dout,
  output logic          dout_en,
  output logic          dout_undef
);
  logic [1:0]    rst_sync;
  logic          rst_core_n;
  logic          we_s, din_s, ce_fall, ce_rise, we_fall;
  logic [AW-1:0] addr_s, addr_l;
  logic          rd_bit, wr_en, wr_bit;
  cyc_kind_e     mode_w;
  logic [TW-1:0] acc_cnt;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  sram_pin_sampler #(.AW(AW)) smp_i (
    .clk(clk), .rst_n(rst_core_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .we_s(we_s), .addr_s(addr_s), .din_s(din_s),
    .ce_fall(ce_fall), .ce_rise(ce_rise), .we_fall(we_fall)
  );

  sram_cycle_ctrl #(.AW(AW), .ACC_CLKS(ACC_CLKS), .LEAD_CLKS(LEAD_CLKS)) ctl_i (
    .clk(clk), .rst_n(rst_core_n), .ce_fall(ce_fall), .ce_rise(ce_rise), .we_fall(we_fall),
    .we_s(we_s), .addr_s(addr_s), .din_s(din_s), .rd_bit(rd_bit),
    .mode(mode_w), .acc_cnt(acc_cnt), .addr_l(addr_l), .wr_en(wr_en), .wr_bit(wr_bit),
    .dout(dout), .dout_en(dout_en), .dout_undef(dout_undef)
  );

  sram_bit_array #(.AW(AW)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(addr_l), .wr_bit(wr_bit),
    .rd_addr(addr_l), .rd_bit(rd_bit)
  );
endmodule

// File: rtl/sram4k_ce_checker.sv
module sram4k_ce_checker
  import sram4k_pkg::*;
#(
  parameter int ACC_CLKS = 20,
  localparam int TW = $clog2(ACC_CLKS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_rise,
  input cyc_kind_e     mode,
  input logic [TW-1:0] acc_cnt,
  input logic          wr_en,
  input logic          dout,
  input logic          dout_en,
  input logic          dout_undef
);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CYC_IDLE) |-> (!dout_en && !dout_undef));

  assert_early_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CYC_EWRITE) |-> !dout_en);

  assert_rise_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> !dout_en);

  assert_undef_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_undef |-> (dout_en && !dout));

  assert_access_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == CYC_READ) && (acc_cnt < TW'(ACC_CLKS))) |-> !dout_en);

  assert_commit_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ce_rise);
endmodule

bind sram4k_ce_model sram4k_ce_checker #(.ACC_CLKS(ACC_CLKS)) chk_i (
  .clk(clk), .rst_n(rst_core_n), .ce_rise(ce_rise), .mode(mode_w), .acc_cnt(acc_cnt),
  .wr_en(wr_en), .dout(dout), .dout_en(dout_en), .dout_undef(dout_undef)
);

// File: tb/sram4k_ce_model_tb_top.sv
`timescale 1ns/1ps
module sram4k_ce_model_tb_top;
  localparam int ACC  = 20;
  localparam int LEAD = 4;

  logic clk = 1'b0;
  logic rst_n, ce_n, we_n, din;
  logic [11:0] addr;
  logic dout, dout_en, dout_undef;

  always #4 clk = ~clk;

  sram4k_ce_model #(.AW(12), .ACC_CLKS(ACC), .LEAD_CLKS(LEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .dout_undef(dout_undef)
  );

  typedef struct {
    string req;
    bit    en;
    bit    d;
    bit    u;
    bit    chk_d;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input bit en, input bit d, input bit u, input bit chk_d);
    exp_t e;
    e.req = req; e.en = en; e.d = d; e.u = u; e.chk_d = chk_d;
    exp_q.push_back(e);
  endtask

  // Monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (dout_en !== e.en || dout_undef !== e.u || (e.chk_d && dout !== e.d)) begin
          errors++;
          $display("FAIL %s: got en=%0b d=%0b undef=%0b, expected en=%0b d=%0b undef=%0b",
                   e.req, dout_en, dout, dout_undef, e.en, e.d, e.u);
        end
      end
    end
  end

  task automatic early_write(input logic [11:0] a, input bit d);
    we_n = 1'b0; din = d; addr = a;
    tick(1);
    ce_n = 1'b0;
    tick(3);
    din = ~d; addr = ~a;                 // R5, R3: ignored after latching
    expect_out("R5 early write output off", 1'b0, 1'b0, 1'b0, 1'b0);
    tick(ACC + 3);
    expect_out("R5 early write output off late", 1'b0, 1'b0, 1'b0, 1'b0);
    ce_n = 1'b1; we_n = 1'b1;
    tick(3);
  endtask

  task automatic read_chk(input logic [11:0] a, input bit exp_d, input string req);
    ce_n = 1'b0; we_n = 1'b1; addr = a;
    tick(1);
    addr = ~a;                           // R3: address change after latch
    tick(ACC);
    expect_out({req, " (R2 access window)"}, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(1);
    expect_out({req, " (R2 data valid)"}, 1'b1, exp_d, 1'b0, 1'b1);
    ce_n = 1'b1;
    tick(2);
    expect_out("R4 output off after chip enable rise", 1'b0, 1'b0, 1'b0, 1'b0);
    tick(2);
  endtask

  task automatic rmw(input logic [11:0] a, input bit new_d, input bit old_d,
                     input int gap, input int lead, input bit undef);
    ce_n = 1'b0; we_n = 1'b1; addr = a;
    tick(gap);
    din = new_d; we_n = 1'b0;
    tick(1);
    din = ~new_d;                        // R6: ignored after write-enable fall
    tick(lead - 1);
    if (undef) expect_out("R8 undefined output forced", 1'b1, 1'b0, 1'b1, 1'b1);
    else       expect_out("R6 old data held", 1'b1, old_d, 1'b0, 1'b1);
    ce_n = 1'b1; we_n = 1'b1;
    tick(3);
    expect_out("R4 output off after read-modify-write", 1'b0, 1'b0, 1'b0, 1'b0);
    tick(2);
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; din = 1'b0; addr = '0;
    tick(3);
    expect_out("R1 outputs off in reset", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick(4);
    expect_out("R1 outputs off after reset", 1'b0, 1'b0, 1'b0, 1'b0);

    early_write(12'h000, 1'b1);
    early_write(12'hFFF, 1'b1);
    early_write(12'h5A5, 1'b0);
    early_write(12'h5A4, 1'b1);
    early_write(12'h001, 1'b0);

    read_chk(12'h000, 1'b1, "R2 R3 read 000");
    read_chk(12'hFFF, 1'b1, "R2 R3 read FFF");
    read_chk(12'h5A5, 1'b0, "R5 read 5A5");
    read_chk(12'h5A4, 1'b1, "R5 read 5A4");
    read_chk(12'h001, 1'b0, "R3 read 001");

    rmw(12'h5A5, 1'b1, 1'b0, ACC + 3, LEAD, 1'b0);
    read_chk(12'h5A5, 1'b1, "R7 committed with full lead");
    rmw(12'h5A4, 1'b0, 1'b1, ACC + 3, LEAD - 1, 1'b0);
    read_chk(12'h5A4, 1'b1, "R7 short lead leaves cell");
    rmw(12'h000, 1'b0, 1'b1, 3, LEAD, 1'b1);
    read_chk(12'h000, 1'b0, "R8 early write-enable fall still writes");

    // R10: standby activity
    for (int i = 0; i < 8; i++) begin
      we_n = i[0]; din = i[1]; addr = 12'hFFF;
      tick(1);
      expect_out("R10 standby output off", 1'b0, 1'b0, 1'b0, 1'b0);
    end
    we_n = 1'b1;
    tick(2);
    read_chk(12'hFFF, 1'b1, "R10 standby left cell");

    // R9: reset keeps storage
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    read_chk(12'h5A5, 1'b1, "R9 data survives reset");
    read_chk(12'h001, 1'b0, "R9 data survives reset 001");

    tick(3);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected run to complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule